// File: doc/BRIEF.md
# Inverter-Loaded Shift Chain with Output Window

This block is a radiation test structure: a long serial chain of storage stages fed from one data pin. Each stage-to-stage path carries a configurable, even number of inverter levels, so the delay between stages can be made longer without changing the logical value that moves down the chain. A test controller drives an alternating one/zero stream into the chain. Only a narrow window of the last few stages is brought out to pins, where it is compared against the expected pattern.

A build-time mode parameter selects one of two variants. The unmitigated variant has one flop per stage. The mitigated variant keeps three copies of every flop and a majority voter after each triple; the inverter logic between stages stays single. An upset-injection input lets a test invert the value captured by chosen copies of one stage on one clock edge. This emulates an upset in a flop, so masking in the mitigated variant and propagation in the unmitigated variant can be shown at the window.

Top module: `delay_chain_window`

## Requirements
- R1: While rst_n is low, every stage (all three copies in the mitigated variant) is cleared at once, with no clock edge needed, and the window reads 4'b0000. Internal reset release is synchronised to the clock: after rst_n rises, the first edge that captures data is the third rising edge.
- R2: With an even INV_LEVELS (0 and 8 are exercised), a stage-to-stage path passes data without inversion. A constant one or a constant zero on din fills the window with the same value.
- R3: A bit presented on din before rising edge n appears on win_q[j] right after edge n+STAGES-WIN_W+j. With the defaults, win_q[0] shows it after edge n+60.
- R4: Once a checkerboard stream has filled the chain, the window reads 4'b0101 or 4'b1010, and it complements on every clock.
- R5: win_q[j] is stage STAGES-WIN_W+j, and win_q[WIN_W-1] is the last stage. Without an injected upset in the window, win_q[j+1] after an edge equals win_q[j] before it.
- R6: With TRIPLE=1, a flip_mask that has exactly one bit set never changes the window, whatever stage flip_stage selects.
- R7: With TRIPLE=0, any nonzero flip_mask inverts the value that stage flip_stage loads on that edge. The error reaches win_q[j] (stage STAGES-WIN_W+j) STAGES-WIN_W+j-flip_stage edges later, and it is visible on the window.
- R8: With TRIPLE=1, a flip_mask with two or three bits set corrupts the stage it selects, exactly as in the unmitigated variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock |
| rst_n | input | 1 | Active-low reset; asserts at once, and its release is synchronised |
| din | input | 1 | Serial data into stage 0 |
| flip_mask | input | 3 | Copies of the selected stage whose captured value is inverted on this edge (bit k = copy k); in the unmitigated variant, any set bit flips the single flop |
| flip_stage | input | $clog2(STAGES) | Index of the stage targeted by flip_mask |
| win_q | output | WIN_W | Voted outputs of the last WIN_W stages, with the oldest stage in the most significant bit |

## Verification
The bench runs a mitigated instance with eight inverter levels and an unmitigated instance with none, side by side from the same inputs. It compares each window every cycle against an independent shift model. The corner cases are these. A single-copy flip on the very last stage is the case where a voter that trusted one copy would leak the error straight to the pins. A double-copy flip must still get through, which catches a voter stuck in masking. An injected error must appear in the unmitigated window on exactly the predicted edge, which catches an off-by-one in the stage ordering or the window tap. A mid-stream asynchronous reset and the two-edge release delay are also checked, because a design with a wrong synchroniser depth would shift the whole stream by one or more cycles.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int TMR_COPIES = 3;

  function automatic logic vote3(input logic [TMR_COPIES-1:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/dcw_rst_sync.sv
module dcw_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[DEPTH-1];

endmodule

// File: rtl/dcw_inv_path.sv
module dcw_inv_path #(
  parameter int LEVELS = 8
) (
  input  logic a,
  output logic y
);

  generate
    if (LEVELS == 0) begin : g_wire
      assign y = a;
    end else begin : g_inv
      logic [LEVELS:0] node;
      assign node[0] = a;
      for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        assign node[i+1] = ~node[i];
      end
      assign y = node[LEVELS];
    end
  endgenerate

endmodule

// File: rtl/dcw_cell.sv
module dcw_cell
  import dcw_pkg::*;
#(
  parameter bit TRIPLE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  d,
  input  logic [TMR_COPIES-1:0] flip,
  output logic                  q
);

  localparam int COPIES = TRIPLE ? TMR_COPIES : 1;

  logic [COPIES-1:0] cp_q;
  logic [COPIES-1:0] cp_d;

  generate
    if (TRIPLE) begin : g_tmr
      always_comb begin
        cp_d = {COPIES{d}} ^ flip;
      end
      assign q = vote3(cp_q);
    end else begin : g_single
      always_comb begin
        cp_d = d ^ (|flip);
      end
      assign q = cp_q[0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q <= '0;
    end else begin
      cp_q <= cp_d;
    end
  end

endmodule

// File: rtl/delay_chain_window.sv
module delay_chain_window
  import dcw_pkg::*;
#(
  parameter int STAGES     = 64,
  parameter int INV_LEVELS = 8,
  parameter int WIN_W      = 4,
  parameter bit TRIPLE     = 1'b1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      din,
  input  logic [TMR_COPIES-1:0]     flip_mask,
  input  logic [$clog2(STAGES)-1:0] flip_stage,
  output logic [WIN_W-1:0]          win_q
);

  localparam int IDX_W   = $clog2(STAGES);
  localparam int WIN_LO  = STAGES - WIN_W;

  logic              rst_core_n;
  logic [STAGES-1:0] stage_q;

  dcw_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic                  d_k;
    logic [TMR_COPIES-1:0] flip_k;

    if (k == 0) begin : g_head
      assign d_k = din;
    end else begin : g_link
      dcw_inv_path #(.LEVELS(INV_LEVELS)) u_path (
        .a (stage_q[k-1]),
        .y (d_k)
      );
    end

    assign flip_k = (flip_stage == IDX_W'(k)) ? flip_mask : '0;

    dcw_cell #(.TRIPLE(TRIPLE)) u_cell (
      .clk   (clk),
      .rst_n (rst_core_n),
      .d     (d_k),
      .flip  (flip_k),
      .q     (stage_q[k])
    );
  end

  assign win_q = stage_q[STAGES-1:WIN_LO];

endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int STAGES = 64,
  parameter int WIN_W  = 4,
  parameter bit TRIPLE = 1'b1,
  parameter int IDX_W  = 6
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic [2:0]       flip_mask,
  input logic [IDX_W-1:0] flip_stage,
  input logic [WIN_W-1:0] win_q
);

  localparam logic [IDX_W-1:0] LAST   = IDX_W'(STAGES - 1);
  localparam logic [IDX_W-1:0] WIN_LO = IDX_W'(STAGES - WIN_W);

  logic hits_last;
  logic shift_ok;

  assign hits_last = (flip_stage == LAST);
  assign shift_ok  = TRIPLE ? ($countones(flip_mask) <= 1)
                            : ((flip_mask == 3'b000) || (flip_stage <= WIN_LO));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_core_n |-> (win_q == '0));

  p_window_shift_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    shift_ok |=> (win_q[WIN_W-1:1] == $past(win_q[WIN_W-2:0])));

  generate
    if (TRIPLE) begin : g_tmr_chk
      p_single_masked_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
        (($countones(flip_mask) == 1) && hits_last)
          |=> (win_q[WIN_W-1] == $past(win_q[WIN_W-2])));

      p_double_exposed_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
        (($countones(flip_mask) >= 2) && hits_last)
          |=> (win_q[WIN_W-1] != $past(win_q[WIN_W-2])));
    end else begin : g_plain_chk
      p_plain_exposed_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
        ((flip_mask != 3'b000) && hits_last)
          |=> (win_q[WIN_W-1] != $past(win_q[WIN_W-2])));
    end
  endgenerate

endmodule

bind delay_chain_window dcw_checker #(
  .STAGES (STAGES),
  .WIN_W  (WIN_W),
  .TRIPLE (TRIPLE),
  .IDX_W  (IDX_W)
) u_dcw_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .flip_mask  (flip_mask),
  .flip_stage (flip_stage),
  .win_q      (win_q)
);

// File: tb/delay_chain_window_tb.sv
module delay_chain_window_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 64;
  localparam int WIN_W      = 4;
  localparam int IDX_W      = $clog2(STAGES);
  localparam int WD_CYCLES  = 100000;

  typedef struct packed {
    logic [1:0] pat;    // 0 checker, 1 ones, 2 zeros, 3 pairs
    logic [7:0] len;
    logic [2:0] mask;   // applied on the first cycle of the entry
    logic [5:0] stage;
    logic [3:0] tag;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'd80, 3'b000, 6'd0,  4'd4},
    '{2'd1, 8'd70, 3'b000, 6'd0,  4'd2},
    '{2'd2, 8'd70, 3'b000, 6'd0,  4'd2},
    '{2'd3, 8'd70, 3'b000, 6'd0,  4'd5},
    '{2'd0, 8'd40, 3'b001, 6'd63, 4'd6},
    '{2'd0, 8'd80, 3'b100, 6'd10, 4'd6},
    '{2'd0, 8'd80, 3'b010, 6'd0,  4'd7},
    '{2'd0, 8'd40, 3'b011, 6'd62, 4'd8},
    '{2'd1, 8'd70, 3'b111, 6'd30, 4'd8},
    '{2'd0, 8'd70, 3'b000, 6'd0,  4'd3}
  };

  logic             clk;
  logic             rst_n;
  logic             din;
  logic [2:0]       flip_mask;
  logic [IDX_W-1:0] flip_stage;
  logic [WIN_W-1:0] win_t;
  logic [WIN_W-1:0] win_p;

  logic [STAGES-1:0] m_t;
  logic [STAGES-1:0] m_p;
  int                rel_cnt;
  int                n_vec;
  int                n_bad;
  int                ph;
  bit                done;

  delay_chain_window #(
    .STAGES(STAGES), .INV_LEVELS(8), .WIN_W(WIN_W), .TRIPLE(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .flip_mask(flip_mask),
    .flip_stage(flip_stage), .win_q(win_t)
  );

  delay_chain_window #(
    .STAGES(STAGES), .INV_LEVELS(0), .WIN_W(WIN_W), .TRIPLE(1'b0)
  ) plain_i (
    .clk(clk), .rst_n(rst_n), .din(din), .flip_mask(flip_mask),
    .flip_stage(flip_stage), .win_q(win_p)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string who,
                     input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s window act=%b exp=%b at %0t", req, who, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, "tmr",   win_t, m_t[STAGES-1 -: WIN_W]);
    chk(req, "plain", win_p, m_p[STAGES-1 -: WIN_W]);
  endtask

  // One clock: drive at the falling edge, model the rising edge, return at the next falling edge.
  task automatic step(input logic d, input logic [2:0] m, input logic [IDX_W-1:0] s);
    din        = d;
    flip_mask  = m;
    flip_stage = s;
    @(posedge clk);
    if (!rst_n) begin
      m_t = '0; m_p = '0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      m_t = '0; m_p = '0; rel_cnt++;
    end else begin
      m_t = {m_t[STAGES-2:0], d};
      m_p = {m_p[STAGES-2:0], d};
      if (m != 3'b000)         m_p[s] = ~m_p[s];
      if ($countones(m) >= 2)  m_t[s] = ~m_t[s];
    end
    @(negedge clk);
    flip_mask = 3'b000;
  endtask

  function automatic logic pat_bit(input logic [1:0] p, input int phase);
    case (p)
      2'd0:    return phase[0];
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      default: return phase[1];
    endcase
  endfunction

  initial begin
    done = 1'b0;
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WIN_W-1:0] prev;
    n_vec = 0; n_bad = 0; ph = 0; rel_cnt = 0;
    m_t = '0; m_p = '0;
    din = 1'b0; flip_mask = 3'b000; flip_stage = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    @(negedge clk);
    repeat (3) step(1'b1, 3'b000, '0);
    // R1: cleared while held in reset
    chk("R1", "tmr",   win_t, 4'b0000);
    chk("R1", "plain", win_p, 4'b0000);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < int'(VECS[v].len); c++) begin
        step(pat_bit(VECS[v].pat, ph), (c == 0) ? VECS[v].mask : 3'b000,
             VECS[v].stage);
        ph++;
        chk_both(tag_name(VECS[v].tag));
      end
    end

    // R4: checkerboard window complements every cycle
    prev = win_t;
    for (int c = 0; c < 8; c++) begin
      step(ph[0], 3'b000, '0);
      ph++;
      chk("R4", "tmr",   win_t, ~prev);
      chk("R4", "plain", win_p, ~prev);
      prev = win_t;
    end
    chk("R4", "tmr", ((win_t == 4'b0101) || (win_t == 4'b1010)) ? win_t : 4'bxxxx, win_t);

    // R7: flip at stage 20 of the plain chain reaches stage 60 (win bit 0) 40 edges later
    repeat (STAGES) step(1'b0, 3'b000, '0);
    step(1'b0, 3'b001, 6'd20);
    repeat (39) step(1'b0, 3'b000, '0);
    chk("R7", "plain", win_p, 4'b0000);
    step(1'b0, 3'b000, '0);
    chk("R7", "plain", win_p, 4'b0001);
    chk("R6", "tmr",   win_t, 4'b0000);

    // R3: single one injected on din reaches win bit 0 after 60 edges
    repeat (STAGES) step(1'b0, 3'b000, '0);
    step(1'b1, 3'b000, '0);
    repeat (59) step(1'b0, 3'b000, '0);
    chk("R3", "tmr", win_t, 4'b0000);
    step(1'b0, 3'b000, '0);
    chk("R3", "tmr",   win_t, 4'b0001);
    chk("R3", "plain", win_p, 4'b0001);

    // R1: asynchronous clear mid-stream, then delayed release
    repeat (STAGES) step(1'b1, 3'b000, '0);
    chk("R2", "tmr", win_t, 4'b1111);
    rst_n = 1'b0;
    #1;
    chk("R1", "tmr async",   win_t, 4'b0000);
    chk("R1", "plain async", win_p, 4'b0000);
    m_t = '0; m_p = '0;
    step(1'b1, 3'b000, '0);
    step(1'b1, 3'b000, '0);
    rst_n = 1'b1;
    for (int c = 0; c < STAGES + 4; c++) begin
      step(1'b1, 3'b000, '0);
      chk_both("R1");
    end
    chk("R1", "tmr release", win_t, 4'b1111);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule